// File: doc/BRIEF.md
# Serial Video Word Serializer with Scrambling and NRZI Coding

This block turns a stream of 10-bit video words into a single serial bit stream that runs ten times faster than the word rate. It uses one fast clock, and the block's own word timer divides it by ten. Once per word period the block raises `word_take`. In that cycle it latches the word on `din`, together with the mode controls. The word is then shifted out one bit per clock, least significant bit first.

In the coded path each serial bit passes through a self-synchronizing scrambler with generator x^9 + x^4 + 1. The scrambled bit then goes to an NRZI coder, whose output toggles on a one and holds on a zero. In the raw path the serializer bits reach `sdo` unchanged, and the scrambler and coder state is frozen.

A detector on the parallel side watches for the timing-reference run of one all-ones word followed by two all-zero words. It raises `sync_det` for one word period. An 8-bit source is supported by padding the two low bits with zeros.

Top module: `vser_top`

## Requirements
- R1: With `narrow`=1 at the take cycle, the latched word is `{din[9:2],2'b00}`, so `din[1:0]` has no effect on `sdo` or `sync_det`. With `narrow`=0 the whole of `din` is latched.
- R2: `word_take` is high for exactly one cycle in every ten. It is first asserted a few cycles after reset is released. `word_mark` rises two cycles after each `word_take`, in the cycle when `sdo` carries bit 0 of that word, and exactly ten serial bits follow per word.
- R3: The bits of each word appear on `sdo` least significant bit first.
- R4: In the coded path the scrambled bit is s[n] = d[n] ^ s[n-4] ^ s[n-9]. The scrambler history is zero after reset.
- R5: In the coded path `sdo` is y[n] = y[n-1] ^ s[n], with y = 0 after reset. A matching NRZI decoder and descrambler recover every word exactly.
- R6: `bypass`, sampled at the take cycle, selects the raw path for that whole word. In the raw path `sdo` equals the serializer bit, the scrambler and NRZI state hold, and `sync_det` stays low.
- R7: `sync_det` goes high one cycle after the take cycle of a word, for one word period, when that word and the word before it are 000 and the word two earlier has bits 9:2 all ones (3FC..3FF). Otherwise it is low.
- R8: `sync_off`=1 at the take cycle forces `sync_det` low for that word.
- R9: While `rst_n` is low, `sdo`, `word_mark`, `word_take` and `sync_det` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| din | input | 10 | Parallel video word |
| narrow | input | 1 | 8-bit source: pad the two low bits with zeros |
| bypass | input | 1 | Raw path: skip the scrambler, the NRZI coder and sync detection |
| sync_off | input | 1 | Disable sync detection |
| word_take | output | 1 | Word and controls are latched in this cycle |
| word_mark | output | 1 | `sdo` carries bit 0 of a word |
| sdo | output | 1 | Serial output |
| sync_det | output | 1 | Timing-reference run detected |

## Verification
The bench builds the block with its defaults: 10-bit words, two pad bits, and a 9-stage scrambler tapped at stage 4. These are the exact polynomial and padding width that the bench's own descrambler and sync model reproduce. With these values, full-width and padded runs of the reference sequence can be driven directly, as can near-miss leads such as 3FB, and a padded word 001 that must count as zero. The bench also switches between the raw and coded paths between words. It then checks that the descrambler settles within one word after the coded path resumes.

// File: rtl/vser_pkg.sv
package vser_pkg;
  typedef enum logic {
    PATH_CODED = 1'b0,
    PATH_RAW   = 1'b1
  } vser_path_e;
endpackage

// File: rtl/vser_word_timer.sv
module vser_word_timer #(
  parameter int WORD_W = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic load,
  output logic mark
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic pre_q, pre_d;
  logic mark_q, mark_d;

  always_comb begin
    load   = run && (cnt_q == '0);
    cnt_d  = cnt_q;
    if (run) begin
      cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end
    pre_d  = load;
    mark_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pre_q  <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pre_q  <= pre_d;
      mark_q <= mark_d;
    end
  end

  assign mark = mark_q;
endmodule

// File: rtl/vser_shifter.sv
module vser_shifter
  import vser_pkg::*;
#(
  parameter int WORD_W = 10,
  parameter int PAD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_i,
  input  vser_path_e        path_i,
  output logic              bit_o,
  output vser_path_e        path_o,
  output logic [PAD_W-1:0]  low_o
);
  logic [WORD_W-1:0] sh_q, sh_d;
  vser_path_e        path_q, path_d;

  always_comb begin
    if (load) begin
      sh_d   = word_i;
      path_d = path_i;
    end else begin
      sh_d   = {1'b0, sh_q[WORD_W-1:1]};
      path_d = path_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      path_q <= PATH_CODED;
    end else begin
      sh_q   <= sh_d;
      path_q <= path_d;
    end
  end

  assign bit_o  = sh_q[0];
  assign path_o = path_q;
  assign low_o  = sh_q[PAD_W-1:0];
endmodule

// File: rtl/vser_scrambler.sv
module vser_scrambler #(
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_i,
  input  logic               raw_i,
  output logic               sdo_o,
  output logic [SCR_LEN-1:0] hist_o
);
  logic [SCR_LEN-1:0] hist_q, hist_d;
  logic y_q, y_d;
  logic sdo_q, sdo_d;
  logic s_n, y_n;

  always_comb begin
    s_n    = bit_i ^ hist_q[SCR_TAP-1] ^ hist_q[SCR_LEN-1];
    y_n    = y_q ^ s_n;
    hist_d = hist_q;
    y_d    = y_q;
    if (!raw_i) begin
      hist_d = {hist_q[SCR_LEN-2:0], s_n};
      y_d    = y_n;
    end
    sdo_d = raw_i ? bit_i : y_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      y_q    <= 1'b0;
      sdo_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      y_q    <= y_d;
      sdo_q  <= sdo_d;
    end
  end

  assign sdo_o  = sdo_q;
  assign hist_o = hist_q;
endmodule

// File: rtl/vser_sync_det.sv
module vser_sync_det #(
  parameter int WORD_W = 10,
  parameter int PAD_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word_i,
  input  logic              block_i,
  output logic              det_o
);
  logic lead, zero;
  logic lead1_q, lead1_d, lead2_q, lead2_d, zero1_q, zero1_d;
  logic det_q, det_d;

  always_comb begin
    lead    = &word_i[WORD_W-1:PAD_W];
    zero    = (word_i == '0);
    lead1_d = lead1_q;
    lead2_d = lead2_q;
    zero1_d = zero1_q;
    det_d   = det_q;
    if (load) begin
      lead2_d = lead1_q;
      lead1_d = lead;
      zero1_d = zero;
      det_d   = lead2_q && zero1_q && zero && !block_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead1_q <= 1'b0;
      lead2_q <= 1'b0;
      zero1_q <= 1'b0;
      det_q   <= 1'b0;
    end else begin
      lead1_q <= lead1_d;
      lead2_q <= lead2_d;
      zero1_q <= zero1_d;
      det_q   <= det_d;
    end
  end

  assign det_o = det_q;
endmodule

// File: rtl/vser_top.sv
module vser_top
  import vser_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int PAD_W   = 2,
  parameter int SCR_LEN = 9,
  parameter int SCR_TAP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din,
  input  logic              narrow,
  input  logic              bypass,
  input  logic              sync_off,
  output logic              word_take,
  output logic              word_mark,
  output logic              sdo,
  output logic              sync_det
);
  logic [1:0]        rs_q;
  logic              rst_int_n;
  logic [WORD_W-1:0] word_eff;
  logic              load;
  logic              ser_bit;
  vser_path_e        path_in, path_q;
  logic              raw_q;
  logic [PAD_W-1:0]  pad_low;
  logic [SCR_LEN-1:0] scr_hist;

  // reset asserts at once, leaves after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  always_comb begin
    word_eff = narrow ? {din[WORD_W-1:PAD_W], {PAD_W{1'b0}}} : din;
    path_in  = bypass ? PATH_RAW : PATH_CODED;
    raw_q    = (path_q == PATH_RAW);
  end

  vser_word_timer #(.WORD_W(WORD_W)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .run(rst_int_n), .load(load), .mark(word_mark)
  );

  vser_shifter #(.WORD_W(WORD_W), .PAD_W(PAD_W)) u_shift (
    .clk(clk), .rst_n(rst_int_n), .load(load), .word_i(word_eff),
    .path_i(path_in), .bit_o(ser_bit), .path_o(path_q), .low_o(pad_low)
  );

  vser_scrambler #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_scr (
    .clk(clk), .rst_n(rst_int_n), .bit_i(ser_bit), .raw_i(raw_q),
    .sdo_o(sdo), .hist_o(scr_hist)
  );

  vser_sync_det #(.WORD_W(WORD_W), .PAD_W(PAD_W)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .load(load), .word_i(word_eff),
    .block_i(sync_off | bypass), .det_o(sync_det)
  );

  assign word_take = load;
endmodule

// File: rtl/vser_chk.sv
module vser_chk #(
  parameter int WORD_W  = 10,
  parameter int PAD_W   = 2,
  parameter int SCR_LEN = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               take,
  input logic               mark,
  input logic               narrow,
  input logic               bypass,
  input logic               sync_off,
  input logic               sync_det,
  input logic               raw_q,
  input logic [PAD_W-1:0]   pad_low,
  input logic [SCR_LEN-1:0] hist
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (take) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 32'd1;
    end
  end

  p_take_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && seen_q) |-> (gap_q == 32'(WORD_W - 1)));

  p_mark_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> ##2 mark);

  p_narrow_pad_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (take && narrow) |=> (pad_low == '0));

  p_raw_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q |=> $stable(hist));

  p_raw_nosync_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bypass) |=> !sync_det);

  p_sync_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && sync_off) |=> !sync_det);
endmodule

bind vser_top vser_chk #(.WORD_W(WORD_W), .PAD_W(PAD_W), .SCR_LEN(SCR_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .take(word_take), .mark(word_mark),
  .narrow(narrow), .bypass(bypass), .sync_off(sync_off), .sync_det(sync_det),
  .raw_q(raw_q), .pad_low(pad_low), .hist(scr_hist)
);

// File: tb/sim_vser_top.sv
module sim_vser_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] din;
  logic       narrow, bypass, sync_off;
  logic       word_take, word_mark, sdo, sync_det;

  int compared = 0;
  int mismatched = 0;
  longint cyc = 0;

  typedef struct {
    logic [9:0] w;
    bit         byp;
    bit         skip;
    string      tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc++;

  vser_top u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .narrow(narrow), .bypass(bypass),
    .sync_off(sync_off), .word_take(word_take), .word_mark(word_mark),
    .sdo(sdo), .sync_det(sync_det)
  );

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  // driver state
  bit     have_prev = 0;
  longint prev_cyc = 0;
  bit     h_lead1 = 0, h_lead2 = 0, h_zero1 = 0, last_byp = 0;

  task automatic send(input logic [9:0] w, input bit nar, input bit byp, input bit soff);
    item_t it;
    logic [9:0] eff;
    bit lead, zero, exp;
    din = w; narrow = nar; bypass = byp; sync_off = soff;
    eff = nar ? {w[9:2], 2'b00} : w;
    while (!word_take) @(negedge clk);
    if (have_prev) chk(cyc - prev_cyc == 10, "R2 take spacing", cyc - prev_cyc, 10);
    prev_cyc = cyc; have_prev = 1;
    it.w = eff; it.byp = byp; it.skip = last_byp && !byp;
    it.tag = byp ? "R6 raw word (R3 order)" : (nar ? "R1 padded word" : "R4/R5 round trip");
    q.push_back(it);
    lead = &eff[9:2]; zero = (eff == 10'h000);
    exp = h_lead2 && h_zero1 && zero && !soff && !byp;
    h_lead2 = h_lead1; h_lead1 = lead; h_zero1 = zero; last_byp = byp;
    @(posedge clk); @(negedge clk);
    chk(sync_det == exp, soff ? "R8 sync disabled" : (byp ? "R6 sync in raw path" : "R7 sync flag"),
        sync_det, exp);
  endtask

  // monitor: NRZI decode, descramble, gather words
  logic       yprev;
  logic [8:0] dsh;
  logic [9:0] rawacc, decacc;
  bit         coll;
  int         idx;
  always @(negedge clk) begin
    logic s, db;
    item_t it;
    if (!rst_n) begin
      yprev = 1'b0; dsh = '0; coll = 0; idx = 0;
    end else begin
      s = sdo ^ yprev;
      yprev = sdo;
      db = s ^ dsh[3] ^ dsh[8];
      dsh = {dsh[7:0], s};
      if (word_mark) begin idx = 0; coll = 1; end
      if (coll) begin
        rawacc[idx] = sdo;
        decacc[idx] = db;
        if (idx == 9) begin
          coll = 0;
          if (q.size() > 0) begin
            it = q.pop_front();
            if (!it.skip) begin
              if (it.byp) chk(rawacc == it.w, it.tag, rawacc, it.w);
              else        chk(decacc == it.w, it.tag, decacc, it.w);
            end
          end
        end else idx++;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; din = '0; narrow = 0; bypass = 0; sync_off = 0;
    repeat (3) @(negedge clk);
    chk(sdo == 0, "R9 reset sdo", sdo, 0);
    chk(word_mark == 0, "R9 reset mark", word_mark, 0);
    chk(word_take == 0, "R9 reset take", word_take, 0);
    chk(sync_det == 0, "R9 reset sync", sync_det, 0);
    rst_n = 1'b1;
    // plain coded words, including edge patterns
    send(10'h3FF, 0, 0, 0); send(10'h001, 0, 0, 0); send(10'h200, 0, 0, 0);
    send(10'h2AA, 0, 0, 0); send(10'h155, 0, 0, 0);
    for (int i = 0; i < 6; i++) send(10'($urandom % 1024), 0, 0, 0);
    // R7 reference runs and near misses
    send(10'h3FF, 0, 0, 0); send(10'h000, 0, 0, 0); send(10'h000, 0, 0, 0);
    send(10'h3FC, 0, 0, 0); send(10'h000, 0, 0, 0); send(10'h000, 0, 0, 0);
    send(10'h3FB, 0, 0, 0); send(10'h000, 0, 0, 0); send(10'h000, 0, 0, 0);
    send(10'h3FF, 0, 0, 0); send(10'h000, 0, 0, 0); send(10'h001, 0, 0, 0);
    send(10'h3FF, 0, 0, 0); send(10'h000, 0, 0, 0); send(10'h000, 0, 0, 0);
    send(10'h000, 0, 0, 0);
    // R8: disabled on the closing word
    send(10'h3FF, 0, 0, 0); send(10'h000, 0, 0, 0); send(10'h000, 0, 0, 1);
    // R1: padded source, low bits ignored
    send(10'h3FF, 1, 0, 0); send(10'h001, 1, 0, 0); send(10'h002, 1, 0, 0);
    send(10'h3D3, 1, 0, 0); send(10'h0FF, 1, 0, 0);
    for (int i = 0; i < 4; i++) send(10'($urandom % 1024), 1, 0, 0);
    // R6: raw path, then back to coded (first coded word skipped)
    send(10'h3FF, 0, 1, 0); send(10'h000, 0, 1, 0); send(10'h000, 0, 1, 0);
    send(10'h2C1, 0, 1, 0); send(10'h0F0, 0, 1, 0);
    send(10'h123, 0, 0, 0);
    for (int i = 0; i < 6; i++) send(10'($urandom % 1024), 0, 0, 0);
    send(10'h3FF, 0, 0, 0); send(10'h000, 0, 0, 0); send(10'h000, 0, 0, 0);
    repeat (30) @(negedge clk);
    chk(q.size() == 0, "R2 all words emitted", q.size(), 0);
    finish_run();
  end
endmodule